// File: doc/BRIEF.md
# Asynchronous Byte-Lane SRAM Controller

This block connects a synchronous single-cycle request / acknowledge port to an external asynchronous static RAM. The RAM is 16 bits wide and has one active-low strobe per byte lane. The controller drives the RAM address, an active-low and an active-high chip select, the read and write strobes, and the per-lane strobes. It also drives an output-enable line for the tristate driver on the shared data bus. No RAM timing is left to chance. Each minimum time (write pulse, data setup, access, bus release) is given in nanoseconds. Each is rounded up to whole cycles of the clock period parameter, which defaults to 10 ns.

A host pulses `req` for one cycle with `wr`, `addr`, `be` and `wdata` valid. It then waits for the one-cycle `ack`. A read returns its data on `rdata` in the same cycle as `ack`. A lane whose enable is clear reads back as zero. A request with no byte enabled is acknowledged at once, and the RAM pins are not touched. A write that follows a read is held back until the RAM has had time to release the bus. The controller also turns its own driver on only after the RAM has stopped driving in response to the write strobe.

Top module: `sram_bridge`

## Requirements
- R1: After reset and until the first request, `ack` is 0, `ram_ce_n`, `ram_oe_n`, `ram_we_n` and both bits of `ram_bs_n` are 1, `ram_ce` is 0, and `ram_dq_oe` is 0.
- R2: A request with `be` = 2'b00 produces `ack` = 1 in the cycle after the request, for both reads and writes. No RAM select, strobe or driver is asserted, and the memory contents stay unchanged.
- R3: `be[0]` (data bits 7:0) drives `ram_bs_n[0]` low and `be[1]` (data bits 15:8) drives `ram_bs_n[1]` low. A lane whose enable is clear is neither written nor driven.
- R4: With defaults, a write holds `ram_we_n` low for exactly 6 consecutive cycles. Both chip selects stay active, at least one lane strobe stays low, and `ram_addr` stays stable throughout.
- R5: The data driver `ram_dq_oe` turns on only after `ram_we_n` has been low for 3 full cycles. With defaults, it is on for at least 3 cycles before `ram_we_n` rises.
- R6: `ram_dq_oe` stays on in the cycle in which `ram_we_n` rises, and turns off in the following cycle.
- R7: A read holds `ram_oe_n` low for 8 cycles with `ram_we_n` high. `rdata` carries the RAM bus sampled at the end of that window, and disabled lanes read as zero.
- R8: The controller never drives the bus while the RAM may still be driving it. This includes the 3 cycles of release after `ram_oe_n` rises, when a write directly follows a read.
- R9: `ack` lasts exactly one cycle. In the `ack` cycle every RAM control is inactive and the driver is off.
- R10: All 19 address bits reach `ram_addr`. Word 0 and word 0x7FFFF are distinct locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-cycle request strobe, accepted while idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Word address |
| be | input | 2 | Byte-lane enables, bit 0 = low byte |
| wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with `ack` |
| ram_addr | output | 19 | RAM address |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_ce | output | 1 | RAM chip select, active high |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_bs_n | output | 2 | Lane strobes, active low, bit 0 = low byte |
| ram_dq_out | output | 16 | Data toward the RAM bus |
| ram_dq_oe | output | 1 | Enable of the bus tristate driver |
| ram_dq_in | input | 16 | Data from the RAM bus |

## Verification
The hardest case to reach is a write that follows a read directly. It is the only case where the RAM's slow bus release and the controller's driver can meet. The bench issues a write on the first idle cycle after a read `ack`. Its RAM model keeps driving for three cycles after `ram_oe_n` rises, and the bench counts every cycle in which both sides drive. The RAM model also returns garbage until the access window has fully elapsed, so a read sampled one cycle early is caught.

// File: rtl/sram_bridge_pkg.sv
// Package: shared state type and the ns-to-cycle helpers for the SRAM bridge.
// Assumes positive periods; all helpers are constant functions.
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WPUL,
        ST_WHLD,
        ST_RACC,
        ST_RCAP
    } bst_t;

    // Round a time in ns up to whole clock cycles.
    function automatic int ns2cyc(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_bridge_turn.sv
// Bus turnaround timer: counts the cycles the RAM may still drive the bus
// after its output enable is withdrawn. quiet is high once that time is over.
// Assumes load is a single-cycle pulse at the end of a read.
module sram_bridge_turn #(
    parameter int REL_CYC = 3,
    parameter int REL_W   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic quiet
);
    localparam logic [REL_W-1:0] REL_L = REL_W'(REL_CYC);

    logic [REL_W-1:0] cnt;

    // Load on a read end, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= REL_L;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    // Quiet only when no release time is pending.
    assign quiet = (cnt == '0) && !load;
endmodule

// File: rtl/sram_bridge_rdcap.sv
// Read capture register: one byte lane per generate iteration. An enabled
// lane takes the RAM bus and a disabled lane is cleared. Holds between captures.
module sram_bridge_rdcap #(
    parameter int DW    = 16,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [LANES-1:0] lane_en,
    input  logic [DW-1:0]    dq_in,
    output logic [DW-1:0]    rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Capture or clear this lane on a capture strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata[g*8 +: 8] <= '0;
            else if (cap)
                rdata[g*8 +: 8] <= lane_en[g] ? dq_in[g*8 +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/sram_bridge_fsm.sv
// Access sequencer: turns one host request into a timed RAM read or write.
// Write: select set-up cycle, strobe low for WP_CYC cycles with the driver
// enabled after HZ_CYC cycles, then one hold cycle with the driver still on.
// Read: output enable low for ACC_CYC+1 cycles, then capture and release.
// Assumes req is only pulsed while no access is in flight.
module sram_bridge_fsm
    import sram_bridge_pkg::*;
#(
    parameter int AW      = 19,
    parameter int DW      = 16,
    parameter int LANES   = 2,
    parameter int HZ_CYC  = 3,
    parameter int WP_CYC  = 6,
    parameter int ACC_CYC = 7,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] be,
    input  logic [DW-1:0]    wdata,
    input  logic             quiet,
    output logic             ack,
    output logic             cap,
    output logic             rel_load,
    output logic [LANES-1:0] lane_en,
    output logic [AW-1:0]    ram_addr,
    output logic             ram_ce_n,
    output logic             ram_ce,
    output logic             ram_oe_n,
    output logic             ram_we_n,
    output logic [LANES-1:0] ram_bs_n,
    output logic [DW-1:0]    ram_dq_out,
    output logic             ram_dq_oe
);
    localparam logic [CNT_W-1:0] HZ_L  = CNT_W'(HZ_CYC);
    localparam logic [CNT_W-1:0] WP_L  = CNT_W'(WP_CYC);
    localparam logic [CNT_W-1:0] ACC_L = CNT_W'(ACC_CYC);

    bst_t             st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;

    // Next count value shared by the timed states.
    assign nxt = cnt + 1'b1;

    // Capture and turnaround load happen on the cycle leaving the access window.
    assign cap      = (st == ST_RCAP);
    assign rel_load = (st == ST_RCAP);

    // Main sequencer: state, counter and every registered RAM control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            ack        <= 1'b0;
            lane_en    <= '0;
            ram_addr   <= '0;
            ram_ce_n   <= 1'b1;
            ram_ce     <= 1'b0;
            ram_oe_n   <= 1'b1;
            ram_we_n   <= 1'b1;
            ram_bs_n   <= '1;
            ram_dq_out <= '0;
            ram_dq_oe  <= 1'b0;
        end else begin
            ack <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req) begin
                        if (be == '0) begin
                            ack <= 1'b1;
                        end else begin
                            ram_addr   <= addr;
                            ram_bs_n   <= ~be;
                            lane_en    <= be;
                            ram_ce_n   <= 1'b0;
                            ram_ce     <= 1'b1;
                            ram_dq_out <= wdata;
                            cnt        <= '0;
                            if (wr) begin
                                st <= ST_WSET;
                            end else begin
                                ram_oe_n <= 1'b0;
                                st       <= ST_RACC;
                            end
                        end
                    end
                end
                ST_WSET: begin
                    if (quiet) begin
                        ram_we_n <= 1'b0;
                        cnt      <= '0;
                        st       <= ST_WPUL;
                    end
                end
                ST_WPUL: begin
                    cnt <= nxt;
                    if (nxt == HZ_L) ram_dq_oe <= 1'b1;
                    if (nxt == WP_L) begin
                        ram_we_n <= 1'b1;
                        st       <= ST_WHLD;
                    end
                end
                ST_WHLD: begin
                    ram_dq_oe <= 1'b0;
                    ram_ce_n  <= 1'b1;
                    ram_ce    <= 1'b0;
                    ram_bs_n  <= '1;
                    ack       <= 1'b1;
                    st        <= ST_IDLE;
                end
                ST_RACC: begin
                    cnt <= nxt;
                    if (nxt == ACC_L) st <= ST_RCAP;
                end
                ST_RCAP: begin
                    ram_oe_n <= 1'b1;
                    ram_ce_n <= 1'b1;
                    ram_ce   <= 1'b0;
                    ram_bs_n <= '1;
                    ack      <= 1'b1;
                    st       <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sram_bridge.sv
// Top of the asynchronous SRAM bridge. Converts the ns timing parameters to
// cycle counts and wires sequencer, read capture and turnaround timer.
// Assumes DW is a multiple of 8; lane strobe bit i covers data bits 8i+7:8i.
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int AW        = 19,
    parameter int DW        = 16,
    parameter int T_WC_NS   = 70,
    parameter int T_PWE_NS  = 55,
    parameter int T_AW_NS   = 65,
    parameter int T_SD_NS   = 30,
    parameter int T_HZWE_NS = 30,
    parameter int T_AA_NS   = 70,
    parameter int T_DOE_NS  = 35,
    parameter int T_HZOE_NS = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW/8-1:0] be,
    input  logic [DW-1:0]   wdata,
    output logic            ack,
    output logic [DW-1:0]   rdata,
    output logic [AW-1:0]   ram_addr,
    output logic            ram_ce_n,
    output logic            ram_ce,
    output logic            ram_oe_n,
    output logic            ram_we_n,
    output logic [DW/8-1:0] ram_bs_n,
    output logic [DW-1:0]   ram_dq_out,
    output logic            ram_dq_oe,
    input  logic [DW-1:0]   ram_dq_in
);
    localparam int LANES   = DW / 8;
    localparam int HZ_CYC  = imax(1, ns2cyc(T_HZWE_NS, CLK_NS));
    localparam int SD_CYC  = imax(1, ns2cyc(T_SD_NS, CLK_NS));
    localparam int WP_CYC  = imax(imax(ns2cyc(T_PWE_NS, CLK_NS), HZ_CYC + SD_CYC),
                                  imax(ns2cyc(T_WC_NS, CLK_NS) - 2,
                                       ns2cyc(T_AW_NS, CLK_NS) - 1));
    localparam int ACC_CYC = imax(1, imax(ns2cyc(T_AA_NS, CLK_NS),
                                          ns2cyc(T_DOE_NS, CLK_NS)));
    localparam int REL_CYC = ns2cyc(T_HZOE_NS, CLK_NS);
    localparam int CNT_W   = $clog2(imax(WP_CYC, ACC_CYC) + 1);
    localparam int REL_W   = imax(1, $clog2(REL_CYC + 1));

    logic             quiet;
    logic             cap;
    logic             rel_load;
    logic [LANES-1:0] lane_en;

    sram_bridge_fsm #(
        .AW(AW), .DW(DW), .LANES(LANES), .HZ_CYC(HZ_CYC),
        .WP_CYC(WP_CYC), .ACC_CYC(ACC_CYC), .CNT_W(CNT_W)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .be(be), .wdata(wdata), .quiet(quiet), .ack(ack), .cap(cap),
        .rel_load(rel_load), .lane_en(lane_en), .ram_addr(ram_addr),
        .ram_ce_n(ram_ce_n), .ram_ce(ram_ce), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n), .ram_bs_n(ram_bs_n), .ram_dq_out(ram_dq_out),
        .ram_dq_oe(ram_dq_oe)
    );

    sram_bridge_rdcap #(.DW(DW), .LANES(LANES)) rdcap_i (
        .clk(clk), .rst_n(rst_n), .cap(cap), .lane_en(lane_en),
        .dq_in(ram_dq_in), .rdata(rdata)
    );

    sram_bridge_turn #(.REL_CYC(REL_CYC), .REL_W(REL_W)) turn_i (
        .clk(clk), .rst_n(rst_n), .load(rel_load), .quiet(quiet)
    );
endmodule

// File: rtl/sram_bridge_chk.sv
// Protocol checker for the SRAM bridge pins, bound into every instance.
module sram_bridge_chk #(
    parameter int AW    = 19,
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic [AW-1:0]    ram_addr,
    input logic             ram_ce_n,
    input logic             ram_ce,
    input logic             ram_oe_n,
    input logic             ram_we_n,
    input logic [LANES-1:0] ram_bs_n,
    input logic             ram_dq_oe
);
    assert_sel_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_ce_n && ram_ce && (ram_bs_n != '1)));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_we_n && $past(!ram_we_n)) |-> $stable(ram_addr));

    assert_drv_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_dq_oe) |-> (!ram_we_n && $past(!ram_we_n)));

    assert_drv_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> ram_dq_oe);

    assert_no_rd_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> ram_we_n);

    assert_drv_vs_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> ram_oe_n);

    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

bind sram_bridge sram_bridge_chk #(.AW(AW), .LANES(DW/8)) chk_i (
    .clk(clk), .rst_n(rst_n), .ack(ack), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_ce(ram_ce), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .ram_bs_n(ram_bs_n), .ram_dq_oe(ram_dq_oe)
);

// File: tb/sram_bridge_tb_top.sv
// Scoreboard bench: driver tasks queue expectations, a monitor pops them on
// ack; a cycle-level RAM model answers the pins and watches bus contention.
module sram_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [18:0] addr = '0;
    logic [1:0]  be = '0;
    logic [15:0] wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [18:0] ram_addr;
    logic        ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_dq_oe;
    logic [1:0]  ram_bs_n;
    logic [15:0] ram_dq_out;
    logic [15:0] ram_dq_in = 16'h5A5A;

    int n_chk = 0;
    int n_fail = 0;
    int n_contend = 0;
    int n_nodrv = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic        is_read;
        logic [15:0] exp;
    } item_t;
    item_t sb_q[$];

    logic [15:0] shadow [int];
    logic [15:0] mem [int];
    logic [1:0]  cur_be = '0;

    always #5 clk = ~clk;

    sram_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .be(be),
        .wdata(wdata), .ack(ack), .rdata(rdata), .ram_addr(ram_addr),
        .ram_ce_n(ram_ce_n), .ram_ce(ram_ce), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n), .ram_bs_n(ram_bs_n), .ram_dq_out(ram_dq_out),
        .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [15:0] rd_arr(input bit use_shadow, input int a);
        if (use_shadow) return shadow.exists(a) ? shadow[a] : 16'h0000;
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            chk(1'b0, "watchdog", cycles, 100000);
            finish_run();
        end
    end

    // RAM model: answers reads after the access window, writes on strobe rise.
    int          acc_run = 0;
    int          rel = 0;
    logic        p_we_n = 1'b1, p_dq_oe = 1'b0;
    logic [1:0]  p_bs_n = 2'b11;
    logic [15:0] p_data = '0;
    int          p_addr = 0;
    always @(negedge clk) begin
        logic sel, drive, busy;
        logic [15:0] v;
        sel   = !ram_ce_n && ram_ce && (ram_bs_n != 2'b11);
        drive = sel && !ram_oe_n && ram_we_n;
        acc_run = drive ? acc_run + 1 : 0;
        busy  = drive || (rel > 0);
        if (drive) rel = 3; else if (rel > 0) rel--;
        if (ram_dq_oe && busy) n_contend++;
        if (p_we_n == 1'b0 && ram_we_n == 1'b1 && sel) begin
            v = rd_arr(1'b0, p_addr);
            if (!p_bs_n[0]) v[7:0]  = p_data[7:0];
            if (!p_bs_n[1]) v[15:8] = p_data[15:8];
            mem[p_addr] = v;
            if (!p_dq_oe) n_nodrv++;
        end
        if (drive && acc_run >= 8) begin
            v = rd_arr(1'b0, int'(ram_addr));
            ram_dq_in = {ram_bs_n[1] ? 8'hA5 : v[15:8], ram_bs_n[0] ? 8'hA5 : v[7:0]};
        end else if (busy) ram_dq_in = 16'hDEAD;
        else ram_dq_in = 16'h5A5A;
        p_we_n = ram_we_n; p_dq_oe = ram_dq_oe; p_bs_n = ram_bs_n;
        p_data = ram_dq_out; p_addr = int'(ram_addr);
    end

    // Monitor: pin timing measurements and scoreboard comparison on ack.
    int   we_run = 0, drv_run = 0, oe_run = 0;
    logic m_we_n = 1'b1, m_oe_n = 1'b1, m_dq_oe = 1'b0, hold_chk = 1'b0;
    logic [1:0] m_bs_n = 2'b11;
    always @(negedge clk) begin
        item_t it;
        if (rst_n) begin
            if (hold_chk) begin
                chk(ram_dq_oe == 1'b0, "R6 driver off after hold", ram_dq_oe, 0);
                hold_chk = 1'b0;
            end
            if (!ram_we_n) we_run++;
            if (ram_dq_oe && !ram_we_n) drv_run++;
            if (ram_dq_oe && !m_dq_oe)
                chk(we_run > 3, "R5 driver on after 3 strobe cycles", we_run, 4);
            if (ram_we_n && !m_we_n) begin
                chk(we_run == 6, "R4 write strobe width", we_run, 6);
                chk(drv_run >= 3, "R5 data setup cycles", drv_run, 3);
                chk(ram_dq_oe == 1'b1, "R6 driver held at strobe rise", ram_dq_oe, 1);
                chk(m_bs_n == ~cur_be, "R3 lane strobes", m_bs_n, ~cur_be);
                hold_chk = 1'b1;
                we_run = 0; drv_run = 0;
            end
            if (!ram_oe_n) oe_run++;
            if (ram_oe_n && !m_oe_n) begin
                chk(oe_run == 8, "R7 read window", oe_run, 8);
                oe_run = 0;
            end
            if (ack) begin
                chk({ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_bs_n, ram_dq_oe} == 7'b1011110,
                    "R9 idle controls at ack",
                    {ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_bs_n, ram_dq_oe}, 7'b1011110);
                if (sb_q.size() == 0) chk(1'b0, "R9 unexpected ack", 1, 0);
                else begin
                    it = sb_q.pop_front();
                    if (it.is_read) chk(rdata == it.exp, "R7 read data", rdata, it.exp);
                end
            end
        end
        m_we_n = ram_we_n; m_oe_n = ram_oe_n; m_dq_oe = ram_dq_oe; m_bs_n = ram_bs_n;
    end

    task automatic wait_ack();
        while (!ack) @(negedge clk);
    endtask

    task automatic do_write(input int a, input logic [1:0] b, input logic [15:0] d);
        logic [15:0] v;
        v = rd_arr(1'b1, a);
        if (b[0]) v[7:0]  = d[7:0];
        if (b[1]) v[15:8] = d[15:8];
        shadow[a] = v;
        sb_q.push_back('{is_read: 1'b0, exp: 16'h0});
        @(negedge clk);
        cur_be = b;
        req = 1'b1; wr = 1'b1; addr = 19'(a); be = b; wdata = d;
        @(negedge clk);
        req = 1'b0;
        wait_ack();
    endtask

    task automatic do_read(input int a, input logic [1:0] b);
        logic [15:0] v;
        v = rd_arr(1'b1, a);
        if (!b[0]) v[7:0]  = 8'h00;
        if (!b[1]) v[15:8] = 8'h00;
        sb_q.push_back('{is_read: 1'b1, exp: v});
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = 19'(a); be = b;
        @(negedge clk);
        req = 1'b0;
        wait_ack();
    endtask

    task automatic do_nop(input logic w);
        sb_q.push_back('{is_read: 1'b0, exp: 16'h0});
        @(negedge clk);
        req = 1'b1; wr = w; addr = 19'h10; be = 2'b00; wdata = 16'hFFFF;
        @(negedge clk);
        req = 1'b0;
        chk(ack == 1'b1, "R2 immediate ack", ack, 1);
        chk(ram_ce_n && !ram_ce && ram_bs_n == 2'b11 && !ram_dq_oe && ram_we_n,
            "R2 no RAM access", {ram_ce_n, ram_ce, ram_bs_n}, 4'b1011);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({ack, ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_bs_n, ram_dq_oe} == 8'b01011110,
            "R1 reset state", {ack, ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_bs_n, ram_dq_oe},
            8'b01011110);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk({ack, ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_bs_n, ram_dq_oe} == 8'b01011110,
            "R1 idle before first request",
            {ack, ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_bs_n, ram_dq_oe}, 8'b01011110);

        do_write(16, 2'b11, 16'h1234);
        do_read(16, 2'b11);
        do_write(16, 2'b10, 16'hABCD);   // R3 upper lane only
        do_read(16, 2'b11);
        do_write(16, 2'b01, 16'h99EE);   // R3 lower lane only
        do_read(16, 2'b11);
        do_read(16, 2'b01);              // R7 upper lane reads zero
        do_read(16, 2'b10);              // R7 lower lane reads zero

        do_write(32'h7FFFF, 2'b11, 16'hC0DE);   // R10 top word
        do_write(0, 2'b11, 16'h0F0F);
        do_read(32'h7FFFF, 2'b11);
        do_read(0, 2'b11);

        do_read(16, 2'b11);              // R8 write right after read
        do_write(16, 2'b11, 16'h5678);
        do_read(16, 2'b11);

        do_nop(1'b1);                    // R2 write with no lanes
        do_nop(1'b0);                    // R2 read with no lanes
        do_read(16, 2'b11);              // R2 contents unchanged

        for (int i = 0; i < 8; i++)
            do_write(i * 37 + 100, 2'(i % 3 + 1), 16'(i * 16'h1111 ^ 16'h0F3C));
        for (int i = 0; i < 8; i++) begin
            do_read(i * 37 + 100, 2'b11);
            do_write(i * 37 + 100, 2'b11, 16'(16'hE000 + i));
        end
        for (int i = 0; i < 8; i++)
            do_read(i * 37 + 100, 2'(3 - i % 3));

        repeat (4) @(negedge clk);
        chk(n_contend == 0, "R8 bus contention cycles", n_contend, 0);
        chk(n_nodrv == 0, "R5 write ended without driver", n_nodrv, 0);
        chk(sb_q.size() == 0, "R9 outstanding requests", sb_q.size(), 0);
        finish_run();
    end
endmodule